// File: doc/BRIEF.md
# Combined Integer Multiplier with Overflow Flag

This block multiplies two N-bit integers and returns a product only N bits wide, along with a flag. The flag is raised when the exact product does not fit in that width. One select input picks the operand interpretation, unsigned or two's complement, and both interpretations run through the same datapath. The block never forms the upper half of the product. It computes the N+1 lowest product bits. In parallel, it compares the significant lengths of the operands, and that comparison decides overflow.

A second control input turns on saturation. When it is set and the product overflows, the result becomes the extreme value that lies nearest the true product. In unsigned mode that value is all ones. In signed mode it is the most positive or the most negative value. When saturation is off, the result wraps to the low N bits.

The outputs are registered, so a product appears one clock after its operands are strobed in.

Top module: `ovf_mult`

## Requirements
- R1: When no saturation is applied, `result` equals bits N-1..0 of the exact product under the selected interpretation. `sgn_mode`=1 selects two's complement and 0 selects unsigned.
- R2: In unsigned mode, `ovf` is 1 exactly when the exact product is 2^N or larger.
- R3: In two's complement mode, `ovf` is 1 exactly when the product lies outside -2^(N-1) .. 2^(N-1)-1.
- R4: In two's complement mode, the most negative value times -1 gives `ovf`=1. The same holds for the most negative value times itself.
- R5: A product in which either operand is zero never raises `ovf`, in either mode.
- R6: In unsigned mode with `sat_en`=1 and overflow, `result` is all ones.
- R7: In two's complement mode with `sat_en`=1 and overflow, the saturated value depends on the operand sign bits. If they differ, `result` is the most negative value (only bit N-1 set). If they are equal, it is the most positive value (all bits except N-1 set).
- R8: `valid_out` is 1 in the cycle after each cycle in which `valid_in` is 1, and 0 otherwise.
- R9: `result` and `ovf` keep their values over any cycle in which `valid_in` is 0.
- R10: While reset is held, `valid_out`, `ovf` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands present this cycle |
| a | input | N | First operand |
| b | input | N | Second operand |
| sgn_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| sat_en | input | 1 | 1 = clamp on overflow, 0 = wrap |
| valid_out | output | 1 | Registered result valid |
| result | output | N | Low N product bits or the clamped value |
| ovf | output | 1 | Exact product does not fit in N bits |

## Verification
The hardest case is the narrow band where the operand lengths alone cannot decide overflow. There, only the top bits of the N+1-bit low product separate a fitting result from an overflowing one. Examples are an unsigned product just above or below 2^N, and a signed product of exactly +2^(N-1) or -2^(N-1). Random operands seldom land in that band. The stimulus therefore sweeps every pair of powers of two, and powers of two minus one, in both modes. It also crosses the values 0, 1, all ones, the largest positive and the most negative with one another, under every mode and saturation setting.

// File: rtl/ovf_mult_pkg.sv
package ovf_mult_pkg;

  typedef enum logic [1:0] {
    SAT_KEEP = 2'd0,
    SAT_UMAX = 2'd1,
    SAT_SMAX = 2'd2,
    SAT_SMIN = 2'd3
  } sat_sel_e;

  // Choose the clamp value once overflow is known to apply.
  function automatic sat_sel_e pick_sat(input logic sgn, input logic sa, input logic sb);
    if (!sgn)         return SAT_UMAX;
    else if (sa ^ sb) return SAT_SMIN;
    else              return SAT_SMAX;
  endfunction

endpackage

// File: rtl/ovf_mult_lowprod.sv
// Computes only the N+1 least significant product bits.
module ovf_mult_lowprod #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sgn,
  output logic [N:0]   plow
);
  logic [N:0] ax, bx;

  always_comb begin
    ax   = {sgn & a[N-1], a};
    bx   = {sgn & b[N-1], b};
    plow = ax * bx;
  end
endmodule

// File: rtl/ovf_mult_range.sv
// Overflow prediction from operand significant lengths, settled by the
// top bits of the N+1-bit low product in the ambiguous band.
module ovf_mult_range #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sgn,
  input  logic [N:0]   plow,
  output logic         ovf,
  output logic         ambiguous
);
  localparam int LW = $clog2(2*N+1) + 1;

  logic [LW-1:0] len_a, len_b, len_sum;

  // Unsigned: position of top set bit plus one.
  // Signed: position of top bit differing from the sign, plus one.
  function automatic logic [LW-1:0] sig_len(input logic [N-1:0] v, input logic s);
    logic [LW-1:0] l;
    l = '0;
    for (int i = 0; i < N; i++) begin
      if (s) begin
        if (i < N-1 && (v[i] ^ v[N-1])) l = LW'(i + 1);
      end else begin
        if (v[i]) l = LW'(i + 1);
      end
    end
    return l;
  endfunction

  always_comb begin
    len_a   = sig_len(a, sgn);
    len_b   = sig_len(b, sgn);
    len_sum = len_a + len_b;
    if (sgn) begin
      ambiguous = (len_sum <= LW'(N));
      ovf       = ambiguous ? (plow[N] ^ plow[N-1]) : 1'b1;
    end else begin
      ambiguous = (len_sum == LW'(N + 1));
      if (len_sum <= LW'(N)) ovf = 1'b0;
      else if (ambiguous)    ovf = plow[N];
      else                   ovf = 1'b1;
    end
  end
endmodule

// File: rtl/ovf_mult_outreg.sv
module ovf_mult_outreg
  import ovf_mult_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [N-1:0] low,
  input  logic         ovf_in,
  input  sat_sel_e     sat_sel,
  output logic         valid_out,
  output logic [N-1:0] result,
  output logic         ovf
);
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] res_d;

  always_comb begin
    unique case (sat_sel)
      SAT_UMAX: res_d = '1;
      SAT_SMAX: res_d = SMAX;
      SAT_SMIN: res_d = SMIN;
      default:  res_d = low;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result <= res_d;
        ovf    <= ovf_in;
      end
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(result) && $stable(ovf)));
  assert_umax_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && sat_sel == SAT_UMAX) |=> (result == '1));
  assert_wrap_passes_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && sat_sel == SAT_KEEP) |=> (result == $past(low)));
endmodule

// File: rtl/ovf_mult.sv
module ovf_mult
  import ovf_mult_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         sgn_mode,
  input  logic         sat_en,
  output logic         valid_out,
  output logic [N-1:0] result,
  output logic         ovf
);
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};

  logic [N:0] plow;
  logic       ovf_pred;
  logic       ambiguous;
  sat_sel_e   sat_sel;

  ovf_mult_lowprod #(.N(N)) u_low (
    .a(a), .b(b), .sgn(sgn_mode), .plow(plow)
  );

  ovf_mult_range #(.N(N)) u_range (
    .a(a), .b(b), .sgn(sgn_mode), .plow(plow),
    .ovf(ovf_pred), .ambiguous(ambiguous)
  );

  assign sat_sel = (sat_en && ovf_pred) ? pick_sat(sgn_mode, a[N-1], b[N-1]) : SAT_KEEP;

  ovf_mult_outreg #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .low(plow[N-1:0]), .ovf_in(ovf_pred), .sat_sel(sat_sel),
    .valid_out(valid_out), .result(result), .ovf(ovf)
  );

  assert_zero_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && (a == '0 || b == '0)) |=> !ovf);
  assert_unsigned_bitn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !sgn_mode && plow[N]) |=> ovf);
  assert_signed_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && sgn_mode && (plow[N] ^ plow[N-1])) |=> ovf);
  assert_min_by_neg1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && sgn_mode && a == SMIN && b == '1) |=> ovf);
  assert_signed_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && sgn_mode && sat_en && ovf_pred && (a[N-1] == b[N-1])) |=> (result == SMAX));
  assert_clear_in_reset_R10: assert property (@(posedge clk)
    !rst_n |-> (!valid_out && !ovf && result == '0));
endmodule

// File: tb/ovf_mult_bench.sv
module ovf_mult_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_in = 1'b0;
  logic [N-1:0] a = '0, b = '0;
  logic         sgn_mode = 1'b0, sat_en = 1'b0;
  logic         valid_out, ovf;
  logic [N-1:0] result;

  int checks = 0;
  int fails  = 0;
  logic         e_vld = 1'b0, e_ovf = 1'b0;
  logic [N-1:0] e_res = '0;
  string        e_tag = "R10";

  always #10 clk = ~clk;

  ovf_mult #(.N(N)) u_ovf_mult (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .a(a), .b(b),
    .sgn_mode(sgn_mode), .sat_en(sat_en),
    .valid_out(valid_out), .result(result), .ovf(ovf)
  );

  task automatic check_outputs();
    checks++;
    if (valid_out !== e_vld) begin
      fails++;
      $display("FAIL R8 valid_out actual %0b expected %0b", valid_out, e_vld);
    end
    checks++;
    if (ovf !== e_ovf) begin
      fails++;
      $display("FAIL %s ovf actual %0b expected %0b", e_tag, ovf, e_ovf);
    end
    checks++;
    if (result !== e_res) begin
      fails++;
      $display("FAIL %s result actual %h expected %h", e_tag, result, e_res);
    end
  endtask

  // Reference: full-width product in 64-bit integers.
  task automatic step(input logic [N-1:0] ia, input logic [N-1:0] ib,
                      input logic is, input logic isat, input logic iv);
    longint pa, pb, p, hi, lo;
    logic   ov;
    @(negedge clk);
    check_outputs();
    a = ia; b = ib; sgn_mode = is; sat_en = isat; valid_in = iv;
    e_vld = iv;
    if (!iv) begin
      e_tag = "R9";
      return;
    end
    pa = is ? longint'($signed(ia)) : longint'({1'b0, ia});
    pb = is ? longint'($signed(ib)) : longint'({1'b0, ib});
    p  = pa * pb;
    if (is) begin
      hi = (longint'(1) <<< (N-1)) - 1;
      lo = -(longint'(1) <<< (N-1));
    end else begin
      hi = (longint'(1) <<< N) - 1;
      lo = 0;
    end
    ov = (p > hi) || (p < lo);
    e_ovf = ov;
    if (ov && isat) e_res = (p > hi) ? hi[N-1:0] : lo[N-1:0];
    else            e_res = p[N-1:0];
    if (ia == '0 || ib == '0)                         e_tag = "R5";
    else if (is && ((ia == {1'b1, {(N-1){1'b0}}}) &&
             (ib == '1 || ib == {1'b1, {(N-1){1'b0}}}))) e_tag = "R4";
    else if (ov && isat)                              e_tag = is ? "R7" : "R6";
    else if (ov)                                      e_tag = is ? "R3" : "R2";
    else                                              e_tag = "R1";
  endtask

  initial begin
    logic [N-1:0] corners [5];
    corners[0] = '0; corners[1] = N'(1); corners[2] = '1;
    corners[3] = {1'b0, {(N-1){1'b1}}}; corners[4] = {1'b1, {(N-1){1'b0}}};
    // R10: outputs cleared during reset
    repeat (3) @(negedge clk);
    e_tag = "R10";
    check_outputs();
    rst_n = 1'b1;
    // corners crossed in both modes, wrap and clamp (R1-R7)
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          step(corners[i], corners[j], m[0], m[1], 1'b1);
    // powers of two and their neighbours: ambiguous band
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        step(N'(1) << i, N'(1) << j, 1'b0, j[0], 1'b1);
        step(N'(1) << i, (N'(1) << j) - N'(1), 1'b1, i[0], 1'b1);
        step(-(N'(1) << i), (N'(1) << j) + N'(1), 1'b1, 1'b1, 1'b1);
        step((N'(1) << i) + N'(1), (N'(1) << j) - N'(1), 1'b0, 1'b0, 1'b1);
      end
    // random traffic with idle gaps (R8, R9)
    for (int k = 0; k < 3000; k++)
      step(N'($urandom), N'($urandom >> ($urandom % 16)),
           1'($urandom), 1'($urandom), ($urandom % 4) != 0);
    step('0, '0, 1'b0, 1'b0, 1'b0);
    step('0, '0, 1'b0, 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule